// File: doc/BRIEF.md
# Shadow-Banked Byte Register File

This block is the register store of a small 8-bit processor core. It holds an accumulator, a flag byte, six general byte registers that also form three 16-bit pairs (BC, DE and HL), a 16-bit stack pointer, and an alternate copy of the accumulator, the flags and the three pairs. A single command port exchanges the accumulator and flags with their alternates, swaps all three pairs with their alternates, or swaps DE with HL. Each exchange takes one clock.

A move port takes a raw `01dddsss` opcode and copies one byte register into another. It reports when either field names the memory operand addressed through HL, and it reports a halt for the opcode `0x76`, which has no move meaning. A pair port increments or decrements BC, DE, HL or SP, or loads SP from HL. A byte write port lets the ALU write a result, and a separate flag write port updates the flags. The block drives the accumulator, flags and one selectable operand for the ALU. It drives the four 16-bit pairs for the address unit.

Top module: `shadow_regfile`

## Requirements
- R1: A synchronous reset clears every main and alternate byte register, including both flag bytes, to 0x00, and sets SP to 0xFFFF. These values are visible from the first clock edge after reset is released.
- R2: When `wr_en_i` is set and no higher-priority action is present, `wr_data_i` is written to the register selected by `wr_sel_i` on the next edge. The selector codes are B=0, C=1, D=2, E=3, H=4, L=5 and A=7. Code 6 changes no register.
- R3: `opnd_o` shows the register selected by `opnd_sel_i`, using the R2 codes, in the same cycle. For code 6, `opnd_ind_o` is 1 and `opnd_o` is 0x00. For every other code, `opnd_ind_o` is 0.
- R4: When `mv_valid_i` is set and the opcode has bits 7:6 equal to 01, the register named by bits 2:0 is copied on the next edge into the register named by bits 5:3. An opcode with any other top two bits changes no register.
- R5: A move opcode whose source or destination field is 6, other than 0x76, changes no register. It raises `mv_ind_o` in the same cycle.
- R6: Opcode 0x76 with `mv_valid_i` raises `halt_o` in the same cycle and not `mv_ind_o`. It changes no register.
- R7: `xchg_i`=1 swaps A with alternate A and F with alternate F. No other register changes.
- R8: `xchg_i`=2 swaps BC, DE and HL with their alternates in one edge. A, F and SP are unchanged.
- R9: `xchg_i`=3 swaps DE with HL in the main bank.
- R10: `pair_op_i`=1 increments and `pair_op_i`=2 decrements the pair chosen by `pair_sel_i` (BC=0, DE=1, HL=2, SP=3), wrapping modulo 65536. The flags are unchanged.
- R11: `pair_op_i`=3 copies the full 16-bit HL into SP, whatever `pair_sel_i` is.
- R12: In a cycle with a nonzero `xchg_i`, every other write request is dropped, including pair, move, byte and flag writes.
- R13: Without an exchange, only one of pair operation, move and byte write takes effect, in that priority order. A valid move opcode takes its turn even when it copies nothing. The flag write applies alongside any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mv_valid_i | input | 1 | Move opcode present |
| mv_opcode_i | input | 8 | Move opcode (01dddsss) |
| wr_en_i | input | 1 | Byte write request |
| wr_sel_i | input | 3 | Byte write target code |
| wr_data_i | input | 8 | Byte write data |
| f_we_i | input | 1 | Flag write request |
| f_data_i | input | 8 | Flag write data |
| pair_op_i | input | 2 | 0 none, 1 increment, 2 decrement, 3 SP from HL |
| pair_sel_i | input | 2 | Pair code BC=0 DE=1 HL=2 SP=3 |
| xchg_i | input | 2 | 0 none, 1 AF, 2 three pairs, 3 DE/HL |
| opnd_sel_i | input | 3 | Operand read code |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Flag byte |
| opnd_o | output | 8 | Selected operand |
| opnd_ind_o | output | 1 | Operand code is the HL memory operand |
| bc_o | output | 16 | BC pair |
| de_o | output | 16 | DE pair |
| hl_o | output | 16 | HL pair |
| sp_o | output | 16 | Stack pointer |
| mv_ind_o | output | 1 | Move uses the HL memory operand |
| halt_o | output | 1 | Halt opcode seen |

## Verification
The decode outputs `halt_o`, `mv_ind_o`, `opnd_o` and `opnd_ind_o` are combinational. They are due in the cycle the inputs are applied, so the bench checks them 1 ns after driving the inputs on the falling edge, before the rising edge. Every register effect, whether write, move, pair step or exchange, is due after exactly one rising edge. The bench therefore updates its model once per rising edge and compares the accumulator, flags and all four pairs at the following falling edge. The alternate bank cannot be read directly, so its contents are checked when later exchanges bring them into view.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int DW   = 8;
    localparam int SELW = 3;
    localparam int PW   = 2 * DW;

    typedef logic [DW-1:0] byte_t;
    typedef logic [PW-1:0] word_t;

    typedef enum logic [SELW-1:0] {
        SEL_B = 3'd0, SEL_C = 3'd1, SEL_D = 3'd2, SEL_E = 3'd3,
        SEL_H = 3'd4, SEL_L = 3'd5, SEL_IND = 3'd6, SEL_A = 3'd7
    } sel_e;

    typedef enum logic [1:0] {XC_NONE = 2'd0, XC_AF = 2'd1, XC_BANK = 2'd2, XC_DEHL = 2'd3} xchg_e;
    typedef enum logic [1:0] {PO_NONE = 2'd0, PO_INC = 2'd1, PO_DEC = 2'd2, PO_SPHL = 2'd3} pair_op_e;
    typedef enum logic [1:0] {PR_BC = 2'd0, PR_DE = 2'd1, PR_HL = 2'd2, PR_SP = 2'd3} pair_e;

    typedef struct packed {
        byte_t a; byte_t f;
        byte_t b; byte_t c;
        byte_t d; byte_t e;
        byte_t h; byte_t l;
    } bank_t;

    typedef struct packed {
        logic            copy;
        logic            ind;
        logic            halt;
        logic [SELW-1:0] dst;
        logic [SELW-1:0] src;
    } mv_dec_t;

    typedef struct packed {
        logic  we;
        pair_e sel;
        word_t val;
    } pair_wr_t;

    function automatic byte_t pick(bank_t bk, logic [SELW-1:0] s);
        case (s)
            SEL_B:   return bk.b;
            SEL_C:   return bk.c;
            SEL_D:   return bk.d;
            SEL_E:   return bk.e;
            SEL_H:   return bk.h;
            SEL_L:   return bk.l;
            SEL_A:   return bk.a;
            default: return '0;
        endcase
    endfunction

    function automatic bank_t put(bank_t bk, logic [SELW-1:0] s, byte_t v);
        bank_t r = bk;
        case (s)
            SEL_B:   r.b = v;
            SEL_C:   r.c = v;
            SEL_D:   r.d = v;
            SEL_E:   r.e = v;
            SEL_H:   r.h = v;
            SEL_L:   r.l = v;
            SEL_A:   r.a = v;
            default: r = bk;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rf_move_decode.sv
module rf_move_decode
    import srf_pkg::*;
(
    input  logic       valid_i,
    input  logic [7:0] opcode_i,
    output mv_dec_t    dec_o
);
    localparam logic [1:0] MOVE_GROUP = 2'b01;

    logic in_group, dst_ind, src_ind;

    always_comb begin
        in_group   = valid_i && (opcode_i[7:6] == MOVE_GROUP);
        dst_ind    = (opcode_i[5:3] == SEL_IND);
        src_ind    = (opcode_i[2:0] == SEL_IND);
        dec_o.dst  = opcode_i[5:3];
        dec_o.src  = opcode_i[2:0];
        dec_o.halt = in_group && dst_ind && src_ind;
        dec_o.ind  = in_group && (dst_ind ^ src_ind);
        dec_o.copy = in_group && !dst_ind && !src_ind;
    end
endmodule

// File: rtl/rf_pair_unit.sv
module rf_pair_unit
    import srf_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic [1:0] sel_i,
    input  word_t      bc_i,
    input  word_t      de_i,
    input  word_t      hl_i,
    input  word_t      sp_i,
    output pair_wr_t   wr_o
);
    word_t cur;

    always_comb begin
        case (pair_e'(sel_i))
            PR_BC:   cur = bc_i;
            PR_DE:   cur = de_i;
            PR_HL:   cur = hl_i;
            default: cur = sp_i;
        endcase
        wr_o.we  = (op_i != PO_NONE);
        wr_o.sel = pair_e'(sel_i);
        wr_o.val = cur;
        case (pair_op_e'(op_i))
            PO_INC:  wr_o.val = cur + word_t'(1);
            PO_DEC:  wr_o.val = cur - word_t'(1);
            PO_SPHL: begin
                wr_o.val = hl_i;
                wr_o.sel = PR_SP;
            end
            default: wr_o.val = cur;
        endcase
    end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
    import srf_pkg::*;
(
    input  bank_t           bank_i,
    input  logic [SELW-1:0] sel_i,
    output byte_t           data_o,
    output logic            ind_o
);
    always_comb begin
        ind_o  = (sel_i == SEL_IND);
        data_o = pick(bank_i, sel_i);
    end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import srf_pkg::*;
#(
    parameter logic [15:0] SP_RST = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mv_valid_i,
    input  logic [7:0]  mv_opcode_i,
    input  logic        wr_en_i,
    input  logic [2:0]  wr_sel_i,
    input  logic [7:0]  wr_data_i,
    input  logic        f_we_i,
    input  logic [7:0]  f_data_i,
    input  logic [1:0]  pair_op_i,
    input  logic [1:0]  pair_sel_i,
    input  logic [1:0]  xchg_i,
    input  logic [2:0]  opnd_sel_i,
    output logic [7:0]  acc_o,
    output logic [7:0]  flags_o,
    output logic [7:0]  opnd_o,
    output logic        opnd_ind_o,
    output logic [15:0] bc_o,
    output logic [15:0] de_o,
    output logic [15:0] hl_o,
    output logic [15:0] sp_o,
    output logic        mv_ind_o,
    output logic        halt_o
);
    bank_t    main_q, main_nx, alt_q, alt_nx;
    word_t    sp_q, sp_nx;
    mv_dec_t  mv;
    pair_wr_t pw;

    rf_move_decode u_dec (
        .valid_i (mv_valid_i),
        .opcode_i(mv_opcode_i),
        .dec_o   (mv)
    );

    rf_pair_unit u_pair (
        .op_i (pair_op_i),
        .sel_i(pair_sel_i),
        .bc_i ({main_q.b, main_q.c}),
        .de_i ({main_q.d, main_q.e}),
        .hl_i ({main_q.h, main_q.l}),
        .sp_i (sp_q),
        .wr_o (pw)
    );

    rf_read_mux u_rd (
        .bank_i(main_q),
        .sel_i (opnd_sel_i),
        .data_o(opnd_o),
        .ind_o (opnd_ind_o)
    );

    always_comb begin
        main_nx = main_q;
        alt_nx  = alt_q;
        sp_nx   = sp_q;
        case (xchg_e'(xchg_i))
            XC_AF: begin
                main_nx.a = alt_q.a;  main_nx.f = alt_q.f;
                alt_nx.a  = main_q.a; alt_nx.f  = main_q.f;
            end
            XC_BANK: begin
                {main_nx.b, main_nx.c, main_nx.d, main_nx.e, main_nx.h, main_nx.l} =
                    {alt_q.b, alt_q.c, alt_q.d, alt_q.e, alt_q.h, alt_q.l};
                {alt_nx.b, alt_nx.c, alt_nx.d, alt_nx.e, alt_nx.h, alt_nx.l} =
                    {main_q.b, main_q.c, main_q.d, main_q.e, main_q.h, main_q.l};
            end
            XC_DEHL: begin
                {main_nx.d, main_nx.e} = {main_q.h, main_q.l};
                {main_nx.h, main_nx.l} = {main_q.d, main_q.e};
            end
            default: begin
                if (pw.we) begin
                    case (pw.sel)
                        PR_BC:   {main_nx.b, main_nx.c} = pw.val;
                        PR_DE:   {main_nx.d, main_nx.e} = pw.val;
                        PR_HL:   {main_nx.h, main_nx.l} = pw.val;
                        default: sp_nx = pw.val;
                    endcase
                end else if (mv_valid_i) begin
                    if (mv.copy)
                        main_nx = put(main_q, mv.dst, pick(main_q, mv.src));
                end else if (wr_en_i) begin
                    main_nx = put(main_q, wr_sel_i, wr_data_i);
                end
                if (f_we_i)
                    main_nx.f = f_data_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= '0;
            alt_q  <= '0;
            sp_q   <= SP_RST;
        end else begin
            main_q <= main_nx;
            alt_q  <= alt_nx;
            sp_q   <= sp_nx;
        end
    end

    assign acc_o    = main_q.a;
    assign flags_o  = main_q.f;
    assign bc_o     = {main_q.b, main_q.c};
    assign de_o     = {main_q.d, main_q.e};
    assign hl_o     = {main_q.h, main_q.l};
    assign sp_o     = sp_q;
    assign mv_ind_o = mv.ind;
    assign halt_o   = mv.halt;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (sp_o == SP_RST && acc_o == 8'h00 && flags_o == 8'h00 && hl_o == 16'h0000)); // R1

    AST_HALT_NOT_IND: assert property (@(posedge clk) disable iff (rst)
        !(halt_o && mv_ind_o)); // R6

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (halt_o && xchg_i == 2'd0 && pair_op_i == 2'd0)
        |=> $stable({acc_o, bc_o, de_o, hl_o, sp_o})); // R6

    AST_AF_SWAP: assert property (@(posedge clk) disable iff (rst)
        (xchg_i == 2'd1) |=> (acc_o == $past(alt_q.a) && alt_q.f == $past(flags_o)
                              && $stable({bc_o, de_o, hl_o, sp_o}))); // R7

    AST_BANK_SWAP: assert property (@(posedge clk) disable iff (rst)
        (xchg_i == 2'd2) |=> (hl_o == $past({alt_q.h, alt_q.l})
                              && $stable({acc_o, flags_o, sp_o}))); // R8

    AST_SP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (xchg_i == 2'd0 && pair_op_i == 2'd1 && pair_sel_i == 2'd3)
        |=> sp_o == $past(sp_o) + 16'd1); // R10

    AST_PAIR_KEEPS_F: assert property (@(posedge clk) disable iff (rst)
        (xchg_i == 2'd0 && pair_op_i != 2'd0 && !f_we_i) |=> $stable(flags_o)); // R10

    AST_XCHG_DROPS_SP: assert property (@(posedge clk) disable iff (rst)
        (xchg_i != 2'd0) |=> $stable(sp_o)); // R12
endmodule

// File: tb/sim_shadow_regfile.sv
`timescale 1ns/1ps
module sim_shadow_regfile;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       mv_valid, wr_en, f_we;
    logic [7:0] mv_op, wr_data, f_data;
    logic [2:0] wr_sel, opnd_sel;
    logic [1:0] pair_op, pair_sel, xchg;
    logic [7:0] acc, flags, opnd;
    logic       opnd_ind, mv_ind, halt;
    logic [15:0] bc, de, hl, sp;

    shadow_regfile u0 (
        .clk(clk), .rst(rst), .mv_valid_i(mv_valid), .mv_opcode_i(mv_op),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .f_we_i(f_we), .f_data_i(f_data), .pair_op_i(pair_op), .pair_sel_i(pair_sel),
        .xchg_i(xchg), .opnd_sel_i(opnd_sel), .acc_o(acc), .flags_o(flags),
        .opnd_o(opnd), .opnd_ind_o(opnd_ind), .bc_o(bc), .de_o(de), .hl_o(hl),
        .sp_o(sp), .mv_ind_o(mv_ind), .halt_o(halt)
    );

    int total = 0;
    int bad = 0;

    // model: index = selector code, index 6 holds the flag byte
    logic [7:0]  r[8];
    logic [7:0]  ra[8];
    logic [15:0] msp;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        mv_valid = 0; mv_op = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        f_we = 0; f_data = 0; pair_op = 0; pair_sel = 0; xchg = 0; opnd_sel = 0;
    endtask

    task automatic check_state(string tag);
        chk(tag, "acc", {8'h00, acc}, {8'h00, r[7]});
        chk(tag, "flags", {8'h00, flags}, {8'h00, r[6]});
        chk(tag, "bc", bc, {r[0], r[1]});
        chk(tag, "de", de, {r[2], r[3]});
        chk(tag, "hl", hl, {r[4], r[5]});
        chk(tag, "sp", sp, msp);
    endtask

    task automatic check_comb();
        logic grp, di, si;
        grp = mv_valid && (mv_op[7:6] == 2'b01);
        di  = (mv_op[5:3] == 3'd6);
        si  = (mv_op[2:0] == 3'd6);
        chk("R6", "halt", {15'd0, halt}, {15'd0, grp && di && si});
        chk("R5", "mv_ind", {15'd0, mv_ind}, {15'd0, grp && (di ^ si)});
        chk("R3", "opnd_ind", {15'd0, opnd_ind}, {15'd0, opnd_sel == 3'd6});
        chk("R3", "opnd", {8'h00, opnd}, {8'h00, (opnd_sel == 3'd6) ? 8'h00 : r[opnd_sel]});
    endtask

    task automatic model_step();
        logic [7:0]  t;
        logic [15:0] w;
        int p;
        case (xchg)
            2'd1: for (int k = 6; k < 8; k++) begin t = r[k]; r[k] = ra[k]; ra[k] = t; end
            2'd2: for (int k = 0; k < 6; k++) begin t = r[k]; r[k] = ra[k]; ra[k] = t; end
            2'd3: for (int k = 2; k < 4; k++) begin t = r[k]; r[k] = r[k+2]; r[k+2] = t; end
            default: begin
                if (pair_op != 2'd0) begin
                    p = int'(pair_sel);
                    w = (p == 3) ? msp : {r[2*p], r[2*p+1]};
                    if (pair_op == 2'd1) w = w + 16'd1;
                    else if (pair_op == 2'd2) w = w - 16'd1;
                    else begin w = {r[4], r[5]}; p = 3; end
                    if (p == 3) msp = w;
                    else begin r[2*p] = w[15:8]; r[2*p+1] = w[7:0]; end
                end else if (mv_valid) begin
                    if (mv_op[7:6] == 2'b01 && mv_op[5:3] != 3'd6 && mv_op[2:0] != 3'd6)
                        r[mv_op[5:3]] = r[mv_op[2:0]];
                end else if (wr_en && wr_sel != 3'd6) begin
                    r[wr_sel] = wr_data;
                end
                if (f_we) r[6] = f_data;
            end
        endcase
    endtask

    // inputs already set at a falling edge; check comb now, state after the edge
    task automatic run_cycle(string tag);
        #1 check_comb();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic wr(logic [2:0] s, logic [7:0] d, string tag);
        idle(); wr_en = 1; wr_sel = s; wr_data = d; run_cycle(tag);
    endtask

    initial begin
        string tag;
        void'($urandom(32'd20240));
        idle();
        for (int k = 0; k < 8; k++) begin r[k] = 0; ra[k] = 0; end
        msp = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_state("R1");

        // R2: byte writes, code 6 ignored
        for (int k = 0; k < 8; k++) wr(3'(k), 8'h11 * 8'(k + 1), "R2");
        wr(3'd6, 8'hEE, "R2");
        // R3: operand reads incl. indirect code
        for (int k = 0; k < 8; k++) begin idle(); opnd_sel = 3'(k); run_cycle("R3"); end
        // R4: A <- B, outside-range opcode
        idle(); mv_valid = 1; mv_op = 8'h78; run_cycle("R4");
        idle(); mv_valid = 1; mv_op = 8'h8A; run_cycle("R4");
        // R5: indirect forms
        idle(); mv_valid = 1; mv_op = 8'h46; run_cycle("R5");
        idle(); mv_valid = 1; mv_op = 8'h70; run_cycle("R5");
        // R6: halt hole
        idle(); mv_valid = 1; mv_op = 8'h76; run_cycle("R6");
        // R7, R8, R9 exchanges
        idle(); f_we = 1; f_data = 8'hA5; run_cycle("R7");
        idle(); xchg = 2'd1; run_cycle("R7");
        idle(); xchg = 2'd1; run_cycle("R7");
        idle(); xchg = 2'd2; run_cycle("R8");
        idle(); xchg = 2'd2; run_cycle("R8");
        idle(); xchg = 2'd3; run_cycle("R9");
        // R10: wrap both directions
        idle(); pair_op = 2'd1; pair_sel = 2'd3; run_cycle("R10");
        idle(); pair_op = 2'd2; pair_sel = 2'd3; run_cycle("R10");
        wr(3'd0, 8'h00, "R10"); wr(3'd1, 8'h00, "R10");
        idle(); pair_op = 2'd2; pair_sel = 2'd0; run_cycle("R10");
        // R11
        idle(); pair_op = 2'd3; pair_sel = 2'd1; run_cycle("R11");
        // R12: exchange drops all writes
        idle(); xchg = 2'd3; wr_en = 1; wr_sel = 3'd7; wr_data = 8'h5A;
        f_we = 1; f_data = 8'h3C; pair_op = 2'd1; pair_sel = 2'd3; run_cycle("R12");
        // R13: priorities
        idle(); pair_op = 2'd1; pair_sel = 2'd2; mv_valid = 1; mv_op = 8'h7C;
        wr_en = 1; wr_sel = 3'd7; wr_data = 8'h99; f_we = 1; f_data = 8'h42; run_cycle("R13");
        idle(); mv_valid = 1; mv_op = 8'h76; wr_en = 1; wr_sel = 3'd7; wr_data = 8'h77; run_cycle("R13");

        for (int n = 0; n < 4000; n++) begin
            idle();
            xchg     = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd0;
            pair_op  = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd0;
            pair_sel = 2'($urandom % 4);
            mv_valid = ($urandom % 2 == 0);
            mv_op    = ($urandom % 4 != 0) ? {2'b01, 6'($urandom)} : 8'($urandom);
            wr_en    = ($urandom % 2 == 0);
            wr_sel   = 3'($urandom);
            wr_data  = 8'($urandom);
            f_we     = ($urandom % 4 == 0);
            f_data   = 8'($urandom);
            opnd_sel = 3'($urandom);
            if (xchg == 2'd1) tag = "R7";
            else if (xchg == 2'd2) tag = "R8";
            else if (xchg == 2'd3) tag = "R9";
            else if (pair_op == 2'd3) tag = "R11";
            else if (pair_op != 2'd0) tag = "R10";
            else if (mv_valid) tag = "R4";
            else tag = "R13";
            run_cycle(tag);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule